// File: doc/BRIEF.md
# Triggered Countdown Delay Generator

This block turns one external event into a precisely timed interval. The host first hands over a 32-bit delay word through a valid/ready intake. It then arms the block with a one-cycle strobe. The block next waits for an active-low trigger line. When the synchronized trigger is seen low, the block counts the delay down to zero, one unit every two clocks. At a 200 MHz system clock this gives 10 ns per unit. While it counts, the low 14 bits of the running value drive a parallel output bus, so the countdown can be watched live on pins.

When the count reaches zero, the block sends a one-cycle completion event to an interrupt controller. The event carries an 8-bit vector: a valid flag (value 32) ORed with event number 3, which gives 35. The block then halts. It ignores the trigger until the host arms it again. A delay of zero completes as soon as the trigger is seen and still raises the event.

Intake rules for the delay word: a word is taken on a rising edge where `dly_valid` and `dly_ready` are both high. `dly_ready` is high only while the block is halted. While the block is armed or counting, ready stays low. The host may keep valid asserted and data steady until ready returns; nothing is taken in the meantime. Control (`arm`), the trigger and the event are plain pins without handshake.

Top module: `trig_delay_gen`

## Requirements
- R1: After reset, `par_out` is 0, `evt_valid` is low, `evt_vector` is 0, `dly_ready` is high, and the stored delay is 0.
- R2: A delay word is stored only on an edge with `dly_valid` and `dly_ready` both high. `dly_ready` is high only in the halted state, so a word offered while the block is armed or counting is not stored and the next run uses the old word.
- R3: An `arm` pulse in the halted state loads the stored delay into the count, and `par_out` shows its low 14 bits from the next cycle. An `arm` pulse while the block is armed or counting has no effect.
- R4: `trig_n` is active low and passes through a `SYNC_STAGES`-flop synchronizer (default 2). While armed with `trig_n` high, the count and `par_out` hold and no event occurs.
- R5: Once counting, the count falls by exactly one every `STEP_CLKS` (2) clocks, and `par_out` always equals the count's low 14 bits, including delays wider than 14 bits.
- R6: Counting rising edges from the first edge that samples `trig_n` low as edge 1, `evt_valid` is high in the cycle that follows edge `2*D + SYNC_STAGES + 1`, for delay D.
- R7: A delay of 0 raises the event after `SYNC_STAGES + 1` edges, without a counting phase.
- R8: `evt_valid` lasts exactly one cycle. `evt_vector` is 35 (bit 5 set as the valid flag, bits 1:0 = 3) during that cycle and 0 at all other times.
- R9: After the event the block is halted. `par_out` stays 0, and trigger activity produces no further event until the next `arm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dly_valid | input | 1 | Delay word offered |
| dly_ready | output | 1 | Block can take a delay word (halted) |
| dly_data | input | 32 | Delay in count units |
| arm | input | 1 | One-cycle strobe that loads the delay and waits for trigger |
| trig_n | input | 1 | Asynchronous active-low trigger |
| par_out | output | 14 | Low bits of the running count |
| evt_valid | output | 1 | One-cycle completion event |
| evt_vector | output | 8 | Event vector, 35 during the event, else 0 |

## Verification
The assertions cover the rules that hold on every cycle. The count moves by at most one per step and never on two adjacent cycles. The count holds while halted without `arm`. The stored delay cannot change while ready is low. Every completion produces exactly one event cycle, with the vector zero outside it. Only the bench scenarios can show the end-to-end timing: the edge-exact latency from the trigger to the event for zero, one, wide and random delays, the value seen on the pins at each step, and that a word offered during a run is later found unused.

// File: rtl/tdg_pkg.sv
package tdg_pkg;
  typedef enum logic [1:0] {
    ST_HALT  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_COUNT = 2'd2
  } tdg_state_e;

  localparam int unsigned VEC_W        = 8;
  localparam logic [VEC_W-1:0] VEC_VALID_FLAG = 8'd32;
  localparam logic [VEC_W-1:0] VEC_EVT_NUM    = 8'd3;

  function automatic logic [VEC_W-1:0] done_vector();
    return VEC_VALID_FLAG | VEC_EVT_NUM;
  endfunction
endpackage

// File: rtl/tdg_sync.sv
module tdg_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RESET_VAL}};
    end else begin
      chain[0] <= d_async;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/tdg_delay_reg.sv
module tdg_delay_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halted,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic [DATA_W-1:0] delay_q
);
  assign in_ready = halted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  delay_q <= '0;
    else if (in_valid && in_ready) delay_q <= in_data;
  end

  a_r2_hold_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(delay_q));
endmodule

// File: rtl/tdg_counter.sv
module tdg_counter
  import tdg_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned STEP_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              trig_act,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] cnt,
  output logic              halted,
  output logic              done
);
  localparam int unsigned PH_W = (STEP_CLKS > 2) ? $clog2(STEP_CLKS) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(STEP_CLKS - 1);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  tdg_state_e      st, st_nx;
  logic [PH_W-1:0] phase;
  logic            dec;

  assign dec    = (st == ST_COUNT) && (phase == PH_LAST);
  assign halted = (st == ST_HALT);
  assign done   = ((st == ST_WAIT) && trig_act && (cnt == '0)) ||
                  (dec && (cnt == ONE));

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_HALT:  if (arm) st_nx = ST_WAIT;
      ST_WAIT:  if (trig_act) st_nx = (cnt == '0) ? ST_HALT : ST_COUNT;
      ST_COUNT: if (dec && (cnt == ONE)) st_nx = ST_HALT;
      default:  st_nx = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_HALT;
      cnt   <= '0;
      phase <= '0;
    end else begin
      st <= st_nx;
      if (st == ST_HALT && arm) cnt <= load_val;
      else if (dec)             cnt <= cnt - ONE;
      if (st == ST_COUNT) phase <= dec ? '0 : phase + PH_W'(1);
      else                phase <= '0;
    end
  end

  a_r5_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_COUNT) |=> (cnt == $past(cnt)) || (cnt == $past(cnt) - ONE));
  a_r5_step_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    dec |=> !dec);
  a_r9_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HALT && !arm) |=> $stable(cnt));
  a_r3_arm_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_COUNT && !dec) |=> (st == ST_COUNT));
endmodule

// File: rtl/tdg_event.sv
module tdg_event
  import tdg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  output logic             evt_valid,
  output logic [VEC_W-1:0] evt_vector
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_valid  <= 1'b0;
      evt_vector <= '0;
    end else begin
      evt_valid  <= fire;
      evt_vector <= fire ? done_vector() : '0;
    end
  end
endmodule

// File: rtl/trig_delay_gen.sv
module trig_delay_gen
  import tdg_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned OUT_W       = 14,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STEP_CLKS   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dly_valid,
  output logic              dly_ready,
  input  logic [DATA_W-1:0] dly_data,
  input  logic              arm,
  input  logic              trig_n,
  output logic [OUT_W-1:0]  par_out,
  output logic              evt_valid,
  output logic [VEC_W-1:0]  evt_vector
);
  localparam int unsigned TRIG_LATENCY = SYNC_STAGES;

  logic              trig_n_s;
  logic [DATA_W-1:0] delay_q;
  logic [DATA_W-1:0] cnt;
  logic              halted;
  logic              done;

  tdg_sync #(.STAGES(TRIG_LATENCY), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(trig_n), .q_sync(trig_n_s)
  );

  tdg_delay_reg #(.DATA_W(DATA_W)) u_dreg (
    .clk(clk), .rst_n(rst_n), .halted(halted),
    .in_valid(dly_valid), .in_data(dly_data),
    .in_ready(dly_ready), .delay_q(delay_q)
  );

  tdg_counter #(.DATA_W(DATA_W), .STEP_CLKS(STEP_CLKS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .arm(arm), .trig_act(!trig_n_s),
    .load_val(delay_q), .cnt(cnt), .halted(halted), .done(done)
  );

  tdg_event u_evt (
    .clk(clk), .rst_n(rst_n), .fire(done),
    .evt_valid(evt_valid), .evt_vector(evt_vector)
  );

  assign par_out = cnt[OUT_W-1:0];

  a_r8_event_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> evt_valid);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> !evt_valid);
  a_r8_vector_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |-> (evt_vector == '0));
  a_r9_halted_after_event: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> dly_ready);
endmodule

// File: tb/trig_delay_gen_bench.sv
module trig_delay_gen_bench;
  localparam int SYNC = 2;
  localparam int STEP = 2;
  localparam int OW   = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dly_valid = 1'b0;
  logic        dly_ready;
  logic [31:0] dly_data = '0;
  logic        arm = 1'b0;
  logic        trig_n = 1'b1;
  logic [13:0] par_out;
  logic        evt_valid;
  logic [7:0]  evt_vector;

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  trig_delay_gen u_trig_delay_gen (
    .clk(clk), .rst_n(rst_n), .dly_valid(dly_valid), .dly_ready(dly_ready),
    .dly_data(dly_data), .arm(arm), .trig_n(trig_n), .par_out(par_out),
    .evt_valid(evt_valid), .evt_vector(evt_vector)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_lat(input longint d);
    return STEP * d + SYNC + 1;
  endfunction

  function automatic longint exp_cnt(input longint d, input longint n);
    if (n <= SYNC) return d;
    return d - (n - SYNC - 1) / STEP;
  endfunction

  task automatic write_delay(input logic [31:0] v);
    @(negedge clk);
    chk(dly_ready == 1'b1, "R2 ready while halted", dly_ready, 1);
    dly_valid = 1'b1; dly_data = v;
    @(negedge clk);
    dly_valid = 1'b0; dly_data = '0;
  endtask

  task automatic arm_pulse(input longint d);
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
    chk(par_out == OW'(d), "R3 arm loads count", par_out, OW'(d));
  endtask

  task automatic run_trigger(input longint d, input bit disturb);
    longint n = 0;
    int bad = 0;
    longint bad_act = 0, bad_exp = 0;
    bit got = 1'b0;
    bit quiet = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (par_out != OW'(d) || evt_valid) quiet = 1'b0;
    end
    chk(quiet, "R4 holds while trigger high", par_out, OW'(d));
    trig_n = 1'b0;
    while (!got && n < exp_lat(d) + 8) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (par_out != OW'(exp_cnt(d, n))) begin
        if (bad == 0) begin bad_act = par_out; bad_exp = OW'(exp_cnt(d, n)); end
        bad++;
      end
      if (evt_valid) got = 1'b1;
      else if (disturb && n == 6) begin
        chk(dly_ready == 1'b0, "R2 ready low while counting", dly_ready, 0);
        arm = 1'b1; dly_valid = 1'b1; dly_data = 32'd777;
      end else if (disturb && n == 7) begin
        arm = 1'b0; dly_valid = 1'b0; dly_data = '0;
      end
    end
    arm = 1'b0; dly_valid = 1'b0;
    if (d == 0) chk(got && n == exp_lat(d), "R7 zero delay latency", n, exp_lat(d));
    else        chk(got && n == exp_lat(d), "R6 trigger to event latency", n, exp_lat(d));
    chk(bad == 0, "R5 par_out tracks count", bad_act, bad_exp);
    chk(evt_vector == 8'd35, "R8 vector during event", evt_vector, 35);
    @(negedge clk);
    chk(!evt_valid && evt_vector == 8'd0, "R8 single cycle event", evt_valid, 0);
    trig_n = 1'b1;
    quiet = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      trig_n = (i % 4 < 2);
      if (par_out != 0 || evt_valid) quiet = 1'b0;
    end
    trig_n = 1'b1;
    repeat (SYNC + 2) @(negedge clk);
    if (par_out != 0 || evt_valid) quiet = 1'b0;
    chk(quiet, "R9 halted after event", par_out, 0);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    int unused_seed;
    longint d;
    unused_seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk(par_out == 0 && !evt_valid && evt_vector == 0 && dly_ready,
        "R1 reset state", par_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(par_out == 0 && dly_ready, "R1 state after reset release", par_out, 0);
    arm_pulse(0);
    run_trigger(0, 1'b0);

    write_delay(32'd5);  arm_pulse(5);  run_trigger(5, 1'b0);
    write_delay(32'd0);  arm_pulse(0);  run_trigger(0, 1'b0);
    write_delay(32'd1);  arm_pulse(1);  run_trigger(1, 1'b0);
    write_delay(32'd20); arm_pulse(20); run_trigger(20, 1'b1);
    arm_pulse(20); run_trigger(20, 1'b0);
    write_delay(32'h0000_4005); arm_pulse(32'h4005); run_trigger(32'h4005, 1'b0);

    for (int k = 0; k < 10; k++) begin
      d = longint'($urandom_range(0, 400));
      write_delay(32'(d)); arm_pulse(d); run_trigger(d, (k % 3) == 0);
    end

    finished = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
      $finish;
    end
  end
endmodule